// File: doc/BRIEF.md
# PCIe Address Translation Window Unit

This block holds a bank of programmable address translation windows for a PCIe root port. It has one set of windows for the inbound direction and one for the outbound direction, 16 of each by default. Software reaches them indirectly. It first writes a selector register that names a direction and a window index. Every per-window register access then lands on that selected window.

For outbound traffic, a CPU address presented on `xlatAddr` is compared against every enabled outbound window, and the result appears combinationally.
- A memory-type window replaces the address with the window's target plus the offset into the window.
- A configuration-type window reports the bus number and device/function number held in its target, together with the offset.

A window's programmed values only reach the decoder at the moment its second control register is written. Software can therefore rewrite base, limit and target safely while the old decode stays active.

Top module: `xlat_win_unit`

## Requirements
- R1: The selector register at offset 0x900 keeps bit 31 as direction (1 inbound, 0 outbound) and bits 3:0 as window index; every other bit is dropped on write and reads as 0.
- R2: Per-window registers address the selected window: 0x904 control A, 0x908 control B, 0x90C base low, 0x910 base high, 0x914 limit, 0x918 target low, 0x91C target high; reads return the stored value, and any other offset reads 0 and ignores writes.
- R3: After reset every window has base 0, target 0, limit 0xFFFFFFFF, control A 0 and control B 0, except inbound window 0 whose control B reads 0x80000000; no outbound window decodes.
- R4: Writing base, limit, target or control A leaves the outbound decode unchanged; the decode of an outbound window is replaced only when its control B is written.
- R5: An outbound window whose control B bit 31 was set at that write hits when base <= address <= {base[63:32], limit}; addresses one below or one above miss.
- R6: A hit on a memory window (control A equal to 0) gives `xlatOut` = target + (address - base) with `xlatIsCfg` = 0.
- R7: A hit on a configuration window (control A nonzero) gives `xlatIsCfg` = 1, `xlatOut` = address - base, `cfgBus` = target[31:24], `cfgDevFn` = target[23:16].
- R8: When several enabled outbound windows hit, the lowest index is reported.
- R9: On a miss `xlatNoMatch` = 1 and `xlatHit`, `xlatIdx`, `xlatOut`, `xlatIsCfg`, `cfgBus`, `cfgDevFn` are 0; on a memory hit `cfgBus` and `cfgDevFn` are 0.
- R10: Programming inbound windows never changes outbound translation.
- R11: Rewriting control A and then control B changes a window's type, and the decode of the previous type no longer applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register offset for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| xlatAddr | input | 64 | Outbound CPU address to translate |
| xlatHit | output | 1 | An enabled outbound window matched |
| xlatNoMatch | output | 1 | No enabled outbound window matched |
| xlatIdx | output | 4 | Index of the winning window |
| xlatIsCfg | output | 1 | Winning window is configuration type |
| xlatOut | output | 64 | Translated address or configuration offset |
| cfgBus | output | 8 | Bus number of a configuration hit |
| cfgDevFn | output | 8 | Device/function number of a configuration hit |

## Verification
The assertions assume that `regAddr`, `regWrEn` and `xlatAddr` are stable and defined around each rising edge. The stale-decode property also relies on `xlatAddr` being held whenever it compares two cycles. The bench drives every input a fixed time after the falling edge and holds it through the next rising edge. It steps the translation address only between edges, so both conditions hold. All offsets the bench writes are either mapped offsets or a deliberately unmapped one, and they are never left undefined.

// File: rtl/xlat_win_pkg.sv
package xlat_win_pkg;
  localparam int RegAW = 12;
  localparam logic [RegAW-1:0] OffView   = 12'h900;
  localparam logic [RegAW-1:0] OffCtlA   = 12'h904;
  localparam logic [RegAW-1:0] OffCtlB   = 12'h908;
  localparam logic [RegAW-1:0] OffBaseLo = 12'h90C;
  localparam logic [RegAW-1:0] OffBaseHi = 12'h910;
  localparam logic [RegAW-1:0] OffLimit  = 12'h914;
  localparam logic [RegAW-1:0] OffTgtLo  = 12'h918;
  localparam logic [RegAW-1:0] OffTgtHi  = 12'h91C;

  typedef enum logic [3:0] {
    RD_NONE, RD_VIEW, RD_CTLA, RD_CTLB, RD_BLO, RD_BHI, RD_LIM, RD_TLO, RD_THI
  } rdSel_e;

  typedef struct packed {
    logic wrCtlA;
    logic wrCtlB;
    logic wrBaseLo;
    logic wrBaseHi;
    logic wrLimit;
    logic wrTgtLo;
    logic wrTgtHi;
  } wrStrb_t;
endpackage

// File: rtl/xlat_win_ctrl.sv
module xlat_win_ctrl
  import xlat_win_pkg::*;
#(
  parameter int NumWin = 16,
  localparam int IdxW = $clog2(NumWin)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [RegAW-1:0] regAddr,
  input  logic [31:0]      regWrData,
  output wrStrb_t          strb,
  output rdSel_e           rdSel,
  output logic             selInbound,
  output logic [IdxW-1:0]  selIdx,
  output logic [31:0]      viewVal
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selInbound <= 1'b0;
      selIdx     <= '0;
    end else if (regWrEn && regAddr == OffView) begin
      selInbound <= regWrData[31];
      selIdx     <= regWrData[IdxW-1:0];
    end
  end

  always_comb begin
    viewVal             = '0;
    viewVal[31]         = selInbound;
    viewVal[IdxW-1:0]   = selIdx;
  end

  always_comb begin
    strb          = '0;
    strb.wrCtlA   = regWrEn && regAddr == OffCtlA;
    strb.wrCtlB   = regWrEn && regAddr == OffCtlB;
    strb.wrBaseLo = regWrEn && regAddr == OffBaseLo;
    strb.wrBaseHi = regWrEn && regAddr == OffBaseHi;
    strb.wrLimit  = regWrEn && regAddr == OffLimit;
    strb.wrTgtLo  = regWrEn && regAddr == OffTgtLo;
    strb.wrTgtHi  = regWrEn && regAddr == OffTgtHi;
  end

  always_comb begin
    unique case (regAddr)
      OffView:   rdSel = RD_VIEW;
      OffCtlA:   rdSel = RD_CTLA;
      OffCtlB:   rdSel = RD_CTLB;
      OffBaseLo: rdSel = RD_BLO;
      OffBaseHi: rdSel = RD_BHI;
      OffLimit:  rdSel = RD_LIM;
      OffTgtLo:  rdSel = RD_TLO;
      OffTgtHi:  rdSel = RD_THI;
      default:   rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/xlat_win_dp.sv
module xlat_win_dp
  import xlat_win_pkg::*;
#(
  parameter int NumWin = 16,
  localparam int IdxW    = $clog2(NumWin),
  localparam int NumSlot = 2 * NumWin
) (
  input  logic            clk,
  input  logic            rstN,
  input  wrStrb_t         strb,
  input  rdSel_e          rdSel,
  input  logic            selInbound,
  input  logic [IdxW-1:0] selIdx,
  input  logic [31:0]     viewVal,
  input  logic [31:0]     wrData,
  output logic [31:0]     rdData,
  input  logic [63:0]     xlatAddr,
  output logic            xlatHit,
  output logic            xlatNoMatch,
  output logic [IdxW-1:0] xlatIdx,
  output logic            xlatIsCfg,
  output logic [63:0]     xlatOut,
  output logic [7:0]      cfgBus,
  output logic [7:0]      cfgDevFn
);
  // programmed (software-visible) window state, slot = {direction, index}
  logic [63:0] progBase [NumSlot];
  logic [63:0] progTgt  [NumSlot];
  logic [31:0] progLim  [NumSlot];
  logic [31:0] progCtlA [NumSlot];
  logic [31:0] progCtlB [NumSlot];

  // live outbound decode, captured on a control B write
  logic        liveEn   [NumWin];
  logic        liveCfg  [NumWin];
  logic [63:0] liveBase [NumWin];
  logic [63:0] liveEnd  [NumWin];
  logic [63:0] liveTgt  [NumWin];

  logic [IdxW:0] slot;
  assign slot = {selInbound, selIdx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NumSlot; s++) begin
        progBase[s] <= '0;
        progTgt[s]  <= '0;
        progLim[s]  <= 32'hFFFF_FFFF;
        progCtlA[s] <= '0;
        progCtlB[s] <= (s == NumWin) ? 32'h8000_0000 : 32'h0;
      end
    end else begin
      if (strb.wrCtlA)   progCtlA[slot] <= wrData;
      if (strb.wrCtlB)   progCtlB[slot] <= wrData;
      if (strb.wrBaseLo) progBase[slot][31:0]  <= wrData;
      if (strb.wrBaseHi) progBase[slot][63:32] <= wrData;
      if (strb.wrLimit)  progLim[slot] <= wrData;
      if (strb.wrTgtLo)  progTgt[slot][31:0]  <= wrData;
      if (strb.wrTgtHi)  progTgt[slot][63:32] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < NumWin; w++) begin
        liveEn[w]   <= 1'b0;
        liveCfg[w]  <= 1'b0;
        liveBase[w] <= '0;
        liveEnd[w]  <= '0;
        liveTgt[w]  <= '0;
      end
    end else if (strb.wrCtlB && !selInbound) begin
      liveEn[selIdx]   <= wrData[31];
      liveCfg[selIdx]  <= progCtlA[slot] != 32'h0;
      liveBase[selIdx] <= progBase[slot];
      liveEnd[selIdx]  <= {progBase[slot][63:32], progLim[slot]};
      liveTgt[selIdx]  <= progTgt[slot];
    end
  end

  logic [NumWin-1:0] winHit;
  for (genvar g = 0; g < NumWin; g++) begin : g_match
    assign winHit[g] = liveEn[g] && (xlatAddr >= liveBase[g]) && (xlatAddr <= liveEnd[g]);
  end

  logic [63:0] offset;
  always_comb begin
    logic found;
    found       = 1'b0;
    xlatIdx     = '0;
    xlatIsCfg   = 1'b0;
    xlatOut     = '0;
    cfgBus      = '0;
    cfgDevFn    = '0;
    offset      = '0;
    for (int w = 0; w < NumWin; w++) begin
      if (!found && winHit[w]) begin
        found   = 1'b1;
        xlatIdx = IdxW'(w);
        offset  = xlatAddr - liveBase[w];
        if (liveCfg[w]) begin
          xlatIsCfg = 1'b1;
          xlatOut   = offset;
          cfgBus    = liveTgt[w][31:24];
          cfgDevFn  = liveTgt[w][23:16];
        end else begin
          xlatOut = liveTgt[w] + offset;
        end
      end
    end
    xlatHit     = found;
    xlatNoMatch = !found;
  end

  always_comb begin
    unique case (rdSel)
      RD_VIEW: rdData = viewVal;
      RD_CTLA: rdData = progCtlA[slot];
      RD_CTLB: rdData = progCtlB[slot];
      RD_BLO:  rdData = progBase[slot][31:0];
      RD_BHI:  rdData = progBase[slot][63:32];
      RD_LIM:  rdData = progLim[slot];
      RD_TLO:  rdData = progTgt[slot][31:0];
      RD_THI:  rdData = progTgt[slot][63:32];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/xlat_win_unit.sv
module xlat_win_unit
  import xlat_win_pkg::*;
#(
  parameter int NumWin = 16,
  localparam int IdxW = $clog2(NumWin)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [RegAW-1:0] regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic [63:0]      xlatAddr,
  output logic             xlatHit,
  output logic             xlatNoMatch,
  output logic [IdxW-1:0]  xlatIdx,
  output logic             xlatIsCfg,
  output logic [63:0]      xlatOut,
  output logic [7:0]       cfgBus,
  output logic [7:0]       cfgDevFn
);
  wrStrb_t         strb;
  rdSel_e          rdSel;
  logic            selInbound;
  logic [IdxW-1:0] selIdx;
  logic [31:0]     viewVal;

  xlat_win_ctrl #(.NumWin(NumWin)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb), .rdSel(rdSel),
    .selInbound(selInbound), .selIdx(selIdx), .viewVal(viewVal)
  );

  xlat_win_dp #(.NumWin(NumWin)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel),
    .selInbound(selInbound), .selIdx(selIdx), .viewVal(viewVal),
    .wrData(regWrData), .rdData(regRdData), .xlatAddr(xlatAddr),
    .xlatHit(xlatHit), .xlatNoMatch(xlatNoMatch), .xlatIdx(xlatIdx),
    .xlatIsCfg(xlatIsCfg), .xlatOut(xlatOut), .cfgBus(cfgBus),
    .cfgDevFn(cfgDevFn)
  );
endmodule

// File: rtl/xlat_win_chk.sv
module xlat_win_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [11:0] regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic [63:0] xlatAddr,
  input logic        xlatHit,
  input logic        xlatNoMatch,
  input logic [3:0]  xlatIdx,
  input logic        xlatIsCfg,
  input logic [63:0] xlatOut,
  input logic [7:0]  cfgBus,
  input logic [7:0]  cfgDevFn
);
  logic mapped;
  assign mapped = (regAddr >= 12'h900) && (regAddr <= 12'h91C) && (regAddr[1:0] == 2'b00);

  // R1
  view_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 12'h900) |-> ((regRdData & 32'h7FFF_FFF0) == 32'h0));

  // R1
  view_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 12'h900) |=>
      ((regAddr != 12'h900) || (regRdData == ($past(regWrData) & 32'h8000_000F))));

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (regRdData == 32'h0));

  // R4
  stale_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != 12'h908) |=>
      (!$stable(xlatAddr) || $stable({xlatHit, xlatIdx, xlatIsCfg, xlatOut, cfgBus, cfgDevFn})));

  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlatNoMatch |-> (!xlatHit && xlatIdx == 4'h0 && xlatOut == 64'h0 && !xlatIsCfg
                     && cfgBus == 8'h0 && cfgDevFn == 8'h0));

  // R9
  mem_no_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xlatHit && !xlatIsCfg) |-> (cfgBus == 8'h0 && cfgDevFn == 8'h0));
endmodule

bind xlat_win_unit xlat_win_chk chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .xlatAddr(xlatAddr),
  .xlatHit(xlatHit), .xlatNoMatch(xlatNoMatch), .xlatIdx(xlatIdx),
  .xlatIsCfg(xlatIsCfg), .xlatOut(xlatOut), .cfgBus(cfgBus), .cfgDevFn(cfgDevFn)
);

// File: tb/xlat_win_unit_tb_top.sv
module xlat_win_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] xlatAddr = '0;
  logic        xlatHit, xlatNoMatch, xlatIsCfg;
  logic [3:0]  xlatIdx;
  logic [63:0] xlatOut;
  logic [7:0]  cfgBus, cfgDevFn;

  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;

  xlat_win_unit dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .xlatAddr(xlatAddr),
    .xlatHit(xlatHit), .xlatNoMatch(xlatNoMatch), .xlatIdx(xlatIdx),
    .xlatIsCfg(xlatIsCfg), .xlatOut(xlatOut), .cfgBus(cfgBus), .cfgDevFn(cfgDevFn)
  );

  // behavioural reference: software-visible state plus live outbound decode
  bit [63:0] mBase [2][16];
  bit [63:0] mTgt  [2][16];
  bit [31:0] mLim  [2][16];
  bit [31:0] mCa   [2][16];
  bit [31:0] mCb   [2][16];
  bit        mDir;
  int        mIdx;
  bit        oEn  [16];
  bit        oCfg [16];
  bit [63:0] oLo  [16];
  bit [63:0] oHi  [16];
  bit [63:0] oTgt [16];

  task automatic model_reset();
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 16; w++) begin
        mBase[d][w] = 0; mTgt[d][w] = 0; mLim[d][w] = 32'hFFFF_FFFF;
        mCa[d][w] = 0; mCb[d][w] = 0;
      end
    mCb[1][0] = 32'h8000_0000;
    mDir = 0; mIdx = 0;
    for (int w = 0; w < 16; w++) begin
      oEn[w] = 0; oCfg[w] = 0; oLo[w] = 0; oHi[w] = 0; oTgt[w] = 0;
    end
  endtask

  function automatic bit [31:0] model_read(bit [11:0] a);
    int d = mDir ? 1 : 0;
    case (a)
      12'h900: return {mDir, 27'h0, 4'(mIdx)};
      12'h904: return mCa[d][mIdx];
      12'h908: return mCb[d][mIdx];
      12'h90C: return mBase[d][mIdx][31:0];
      12'h910: return mBase[d][mIdx][63:32];
      12'h914: return mLim[d][mIdx];
      12'h918: return mTgt[d][mIdx][31:0];
      12'h91C: return mTgt[d][mIdx][63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(bit [11:0] a, bit [31:0] v);
    int d = mDir ? 1 : 0;
    case (a)
      12'h900: begin mDir = v[31]; mIdx = int'(v[3:0]); end
      12'h904: mCa[d][mIdx] = v;
      12'h908: begin
        mCb[d][mIdx] = v;
        if (d == 0) begin
          oEn[mIdx]  = v[31];
          oCfg[mIdx] = (mCa[0][mIdx] != 0);
          oLo[mIdx]  = mBase[0][mIdx];
          oHi[mIdx]  = {mBase[0][mIdx][63:32], mLim[0][mIdx]};
          oTgt[mIdx] = mTgt[0][mIdx];
        end
      end
      12'h90C: mBase[d][mIdx][31:0]  = v;
      12'h910: mBase[d][mIdx][63:32] = v;
      12'h914: mLim[d][mIdx] = v;
      12'h918: mTgt[d][mIdx][31:0]  = v;
      12'h91C: mTgt[d][mIdx][63:32] = v;
      default: ;
    endcase
  endtask

  task automatic model_lookup(input bit [63:0] x, output bit hit, output bit [3:0] idx,
                              output bit cfg, output bit [63:0] o, output bit [7:0] bus,
                              output bit [7:0] dfn);
    hit = 0; idx = 0; cfg = 0; o = 0; bus = 0; dfn = 0;
    for (int w = 15; w >= 0; w--) begin
      if (oEn[w] && x >= oLo[w] && x <= oHi[w]) begin
        hit = 1; idx = 4'(w); cfg = oCfg[w];
        if (oCfg[w]) begin
          o = x - oLo[w]; bus = oTgt[w][31:24]; dfn = oTgt[w][23:16];
        end else begin
          o = oTgt[w] + (x - oLo[w]); bus = 0; dfn = 0;
        end
      end
    end
  endtask

  task automatic check(string tag, string what, logic [63:0] got, logic [63:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one clock: drive, compare combinational outputs, then commit the edge
  task automatic step(bit we, bit [11:0] a, bit [31:0] v, bit [63:0] x, string rtag, string xtag);
    bit h; bit [3:0] i; bit c; bit [63:0] o; bit [7:0] b, f;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = v; xlatAddr = x;
    #1;
    model_lookup(x, h, i, c, o, b, f);
    check(rtag, "regRdData", regRdData, model_read(a));
    check(xtag, "xlatHit", xlatHit, h);
    check(xtag, "xlatNoMatch", xlatNoMatch, !h);
    check(xtag, "xlatIdx", xlatIdx, i);
    check(xtag, "xlatIsCfg", xlatIsCfg, c);
    check(xtag, "xlatOut", xlatOut, o);
    check(xtag, "cfgBus", cfgBus, b);
    check(xtag, "cfgDevFn", cfgDevFn, f);
    @(posedge clk);
    if (we) model_write(a, v);
  endtask

  task automatic wr(bit [11:0] a, bit [31:0] v, bit [63:0] x, string tag);
    step(1'b1, a, v, x, tag, tag);
  endtask

  task automatic rd(bit [11:0] a, bit [63:0] x, string tag);
    step(1'b0, a, 32'h0, x, tag, tag);
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R3 reset state
    rd(12'h900, 64'h1000_0010, "R3");
    wr(12'h900, 32'h0000_0005, 64'h0, "R3");
    rd(12'h914, 64'hFFFF_FFFF, "R3");
    rd(12'h90C, 64'h0, "R3");
    rd(12'h908, 64'h8000_0000, "R3");
    wr(12'h900, 32'h8000_0000, 64'h0, "R3");
    rd(12'h908, 64'h1234, "R3");
    rd(12'h91C, 64'h1234, "R3");

    // R1 selector masking
    wr(12'h900, 32'h7FFF_FFF3, 64'h0, "R1");
    rd(12'h900, 64'h0, "R1");
    wr(12'h900, 32'h8000_0012, 64'h0, "R1");
    rd(12'h900, 64'h0, "R1");

    // R4 program outbound 3 memory window, no decode before control B
    wr(12'h900, 32'h0000_0003, 64'h1000_0010, "R4");
    wr(12'h90C, 32'h1000_0000, 64'h1000_0010, "R4");
    wr(12'h914, 32'h1000_FFFF, 64'h1000_0010, "R4");
    wr(12'h91C, 32'h0000_0002, 64'h1000_0010, "R4");
    wr(12'h918, 32'h0000_0000, 64'h1000_0010, "R4");
    wr(12'h904, 32'h0, 64'h1000_0010, "R4");
    wr(12'h908, 32'h8000_0000, 64'h1000_0010, "R6");
    rd(12'h91C, 64'h1000_0010, "R6");
    // R5 boundaries
    rd(12'h914, 64'h1000_0000, "R5");
    rd(12'h914, 64'h1000_FFFF, "R5");
    rd(12'h914, 64'h1001_0000, "R5");
    rd(12'h914, 64'h0FFF_FFFF, "R5");
    // R4 base change without control B keeps old decode
    wr(12'h90C, 32'h1000_4000, 64'h1000_0010, "R4");
    rd(12'h90C, 64'h1000_0010, "R4");
    wr(12'h908, 32'h8000_0000, 64'h1000_0010, "R4");
    rd(12'h90C, 64'h1000_4010, "R4");

    // R7 / R8 overlapping config window at index 1
    wr(12'h900, 32'h0000_0001, 64'h1000_8010, "R7");
    wr(12'h90C, 32'h1000_8000, 64'h1000_8010, "R7");
    wr(12'h914, 32'h1000_8FFF, 64'h1000_8010, "R7");
    wr(12'h918, 32'h1234_0000, 64'h1000_8010, "R7");
    wr(12'h904, 32'h0000_0004, 64'h1000_8010, "R4");
    wr(12'h908, 32'h8000_0000, 64'h1000_8010, "R8");
    rd(12'h904, 64'h1000_8FFF, "R8");
    rd(12'h904, 64'h1000_9000, "R8");
    rd(12'h904, 64'h1000_4010, "R7");

    // R11 switch window 1 to memory type
    wr(12'h904, 32'h0, 64'h1000_8020, "R11");
    rd(12'h904, 64'h1000_8020, "R11");
    wr(12'h908, 32'h8000_0000, 64'h1000_8020, "R11");
    rd(12'h904, 64'h1000_8020, "R11");

    // R10 inbound programming leaves outbound alone
    wr(12'h900, 32'h8000_0000, 64'h1000_8020, "R10");
    wr(12'h90C, 32'h0000_0000, 64'h1000_8020, "R10");
    wr(12'h914, 32'h2000_0000, 64'h1000_8020, "R10");
    wr(12'h918, 32'hABCD_0000, 64'h1000_8020, "R10");
    wr(12'h904, 32'h1, 64'h1000_8020, "R10");
    wr(12'h908, 32'h8000_0000, 64'h0000_0100, "R10");
    rd(12'h918, 64'h0000_0100, "R2");
    wr(12'h900, 32'h8000_0002, 64'h1000_4010, "R10");
    wr(12'h90C, 32'h1000_4000, 64'h1000_4010, "R10");
    wr(12'h908, 32'h8000_0000, 64'h1000_4010, "R10");
    rd(12'h908, 64'h1000_4010, "R2");

    // R2 unmapped offset
    wr(12'h0A0, 32'hFFFF_FFFF, 64'h0, "R2");
    rd(12'h0A0, 64'h0, "R2");
    rd(12'h902, 64'h0, "R2");

    // R5 upper base half: window 7 at 0x1_0000_0000..0x1_0000_0FFF
    wr(12'h900, 32'h0000_0007, 64'h1_0000_0800, "R2");
    wr(12'h910, 32'h0000_0001, 64'h1_0000_0800, "R2");
    wr(12'h90C, 32'h0000_0000, 64'h1_0000_0800, "R2");
    wr(12'h914, 32'h0000_0FFF, 64'h1_0000_0800, "R2");
    wr(12'h91C, 32'h0000_0004, 64'h1_0000_0800, "R2");
    wr(12'h908, 32'h8000_0000, 64'h1_0000_0800, "R5");
    rd(12'h910, 64'h1_0000_0FFF, "R5");
    rd(12'h910, 64'h1_0000_1000, "R5");
    rd(12'h910, 64'h0_0000_0800, "R5");

    // R5 disable window 3
    wr(12'h900, 32'h0000_0003, 64'h1000_4010, "R5");
    wr(12'h908, 32'h0000_0000, 64'h1000_4010, "R9");
    rd(12'h908, 64'h1000_4010, "R9");

    // mixed reads and lookups
    for (int k = 0; k < 300; k++) begin
      bit [11:0] a;
      bit [63:0] x;
      a = 12'h900 + 12'({$urandom_range(0, 8)} * 4);
      x = (k % 3 == 0) ? {32'h1, 20'h0, 12'($urandom)} : {32'h0, 16'h1000, 16'($urandom)};
      if (k % 7 == 0 && a != 12'h908 && a != 12'h900)
        wr(a, $urandom, x, "R4");
      else
        rd(a, x, "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule